// File: doc/BRIEF.md
# Multi-Mode Timer/Counter with Prescaled Time Base

This block is a general-purpose timer/counter built around a low count byte and a high count byte. Three modes are available. In the 13-bit mode the five low bits of the low byte carry into the high byte. In the 16-bit mode the two bytes form one counter. In the reload mode the low byte counts and is refilled from the high byte each time it wraps. Counting is enabled by a run bit and can also be gated by an external level. Each count comes either from a tick of an internal time base or from a falling edge on an external count pin.

The time base is a free-running power-of-two divider of the system clock, with a fourth choice that takes rising edges of a separate slow clock pin. Every count, tick and edge is a one-cycle enable inside the single system clock domain. Software reaches the two count bytes and the overflow flag through a small write/read port. The flag is sticky and is cleared by a software write or by an interrupt acknowledge. In the reload mode each overflow toggles a buzzer square-wave pin, which is released to high impedance when the buzzer is disabled.

Top module: `tmr_unit`

## Requirements
- R1: After reset both count bytes read 00h, the overflow flag and the interrupt request are 0, and the buzzer pin is not driven.
- R2: A write with address 0 loads the low byte and address 1 loads the high byte. Address 2 loads the flag from data bit 0, and this write beats an overflow or an acknowledge in the same cycle. A read returns the low byte at address 0, the high byte at address 1 and the flag in bit 0 at address 2.
- R3: With mode 00 (13-bit) each count increments the low 5 bits of the low byte and leaves its upper 3 bits unchanged. A wrap of those 5 bits increments the high byte. A count at 1FFFh gives 0000h and sets the flag.
- R4: With mode 01 (16-bit) each count increments {high, low}, and a count at FFFFh gives 0000h and sets the flag.
- R5: With mode 10 (reload) only the low byte counts. A count at FFh loads the low byte from the high byte and sets the flag, and the high byte never changes by counting.
- R6: A count is taken only when the run input is 1 and either the gate-enable input is 0 or the synchronized gate pin is high.
- R7: With the source select at 1 the block counts each 1-to-0 transition of the synchronized count pin once, and a steady pin gives no count.
- R8: With the source select at 0 the time-base select picks the tick: 00 every 4 clocks, 01 every 64, 10 every 1024, 11 each rising edge of the slow clock pin.
- R9: The flag stays set until written to 0 or cleared by the acknowledge input. The interrupt request equals the flag.
- R10: Each reload-mode overflow toggles the buzzer state. With the buzzer enable at 1 the buzzer pin drives that state and the drive-enable output is 1. With it at 0 the pin is high impedance and the drive-enable output is 0.
- R11: With mode 11 the count bytes do not change by counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_pin | input | 1 | External count pin (asynchronous) |
| gate_pin | input | 1 | External gate level (asynchronous) |
| slow_pin | input | 1 | Separate slow clock used as time base 11 |
| run_en | input | 1 | Run bit |
| gate_en | input | 1 | Gate enable: 1 makes counting depend on gate_pin |
| ext_sel | input | 1 | Source select: 0 time base, 1 count-pin falling edges |
| mode | input | 2 | 00 13-bit, 01 16-bit, 10 reload, 11 hold |
| tbase | input | 2 | Time-base select |
| buz_en | input | 1 | Buzzer output enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 low, 1 high, 2 flag |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address: 0 low, 1 high, 2 flag |
| rd_data | output | 8 | Read data (combinational) |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |
| buz_oe | output | 1 | 1 while the buzzer pin is driven |
| buz_out | output | 1 | Buzzer pin, high impedance when disabled |

## Verification
On every cycle the assertions check that a flag write lands on the next cycle whatever else happens, that the counts stay frozen while the block is not running or is in the hold mode, that the reload mode never alters the high byte, that the 13-bit mode never touches the upper low-byte bits, that the buzzer state moves only in the reload mode, and that the flag rises only from a write or a running count. Only the bench scenarios show the arithmetic itself: the carry points, the wrap values, the reload sequence over several periods, the exact tick counts of each divider over a fixed window, the edge counting of the external pins, and the buzzer parity after a known number of overflows.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      MODE_13     = 2'b00,
      MODE_16     = 2'b01,
      MODE_RELOAD = 2'b10,
      MODE_HOLD   = 2'b11
   } tmr_mode_e;

   localparam logic [1:0] ADDR_LO   = 2'd0;
   localparam logic [1:0] ADDR_HI   = 2'd1;
   localparam logic [1:0] ADDR_FLAG = 2'd2;

   localparam int EDGE_LEVEL = 0;
   localparam int EDGE_FALL  = 1;
   localparam int EDGE_RISE  = 2;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
   parameter int STAGES = 2,
   parameter int EDGE   = tmr_pkg::EDGE_LEVEL
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], pin};
   end

   if (EDGE == tmr_pkg::EDGE_LEVEL) begin : g_level
      assign q = sh[STAGES-1];
   end else begin : g_edge
      logic prev;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev <= 1'b0;
         else        prev <= sh[STAGES-1];
      end
      if (EDGE == tmr_pkg::EDGE_FALL) begin : g_fall
         assign q = prev & ~sh[STAGES-1];
      end else begin : g_rise
         assign q = ~prev & sh[STAGES-1];
      end
   end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int DIV0 = 4,
   parameter int DIV1 = 64,
   parameter int DIV2 = 1024
) (
   input  logic       clk,
   input  logic       rst_n,
   output logic [2:0] tick
);
   localparam int CW = $clog2(DIV2);
   localparam int DIVS [3] = '{DIV0, DIV1, DIV2};

   if ((DIV0 & (DIV0 - 1)) != 0 || (DIV1 & (DIV1 - 1)) != 0 ||
       (DIV2 & (DIV2 - 1)) != 0) begin : g_bad_pow2
      $error("tmr_prescaler: divisors must be powers of two");
   end
   if (DIV0 < 2 || DIV1 <= DIV0 || DIV2 <= DIV1) begin : g_bad_order
      $error("tmr_prescaler: divisors must rise and start at 2 or more");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + 1'b1;
   end

   for (genvar g = 0; g < 3; g++) begin : g_tick
      localparam logic [CW-1:0] MASK = CW'(DIVS[g] - 1);
      assign tick[g] = (cnt & MASK) == MASK;
   end
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
   parameter int LOW13 = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cnt_tick,
   input  logic [1:0]               mode,
   input  logic                     wr_en,
   input  logic [1:0]               wr_addr,
   input  logic [tmr_pkg::BYTE_W-1:0] wr_data,
   input  logic                     irq_ack,
   output logic [tmr_pkg::BYTE_W-1:0] lo_q,
   output logic [tmr_pkg::BYTE_W-1:0] hi_q,
   output logic                     flag_q,
   output logic                     reload_ovf
);
   import tmr_pkg::*;

   if (LOW13 < 1 || LOW13 >= BYTE_W) begin : g_bad_low
      $error("tmr_core: LOW13 must lie inside the low byte");
   end

   logic [BYTE_W-1:0] lo_n, hi_n;
   logic              ovf;

   always_comb begin
      lo_n = lo_q;
      hi_n = hi_q;
      ovf  = 1'b0;
      if (cnt_tick) begin
         unique case (tmr_mode_e'(mode))
            MODE_13: begin
               if (&lo_q[LOW13-1:0]) begin
                  lo_n[LOW13-1:0] = '0;
                  hi_n            = hi_q + 1'b1;
                  ovf             = &hi_q;
               end else begin
                  lo_n[LOW13-1:0] = lo_q[LOW13-1:0] + 1'b1;
               end
            end
            MODE_16: begin
               {hi_n, lo_n} = {hi_q, lo_q} + 1'b1;
               ovf          = &{hi_q, lo_q};
            end
            MODE_RELOAD: begin
               if (&lo_q) begin
                  lo_n = hi_q;
                  ovf  = 1'b1;
               end else begin
                  lo_n = lo_q + 1'b1;
               end
            end
            default: ;
         endcase
      end
      if (wr_en && wr_addr == ADDR_LO) lo_n = wr_data;
      if (wr_en && wr_addr == ADDR_HI) hi_n = wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q   <= '0;
         hi_q   <= '0;
         flag_q <= 1'b0;
      end else begin
         lo_q <= lo_n;
         hi_q <= hi_n;
         if (wr_en && wr_addr == ADDR_FLAG) flag_q <= wr_data[0];
         else if (ovf)                      flag_q <= 1'b1;
         else if (irq_ack)                  flag_q <= 1'b0;
      end
   end

   assign reload_ovf = ovf && (mode == MODE_RELOAD);
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit #(
   parameter int DIV0        = 4,
   parameter int DIV1        = 64,
   parameter int DIV2        = 1024,
   parameter int SYNC_STAGES = 2,
   parameter int LOW13       = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cnt_pin,
   input  logic       gate_pin,
   input  logic       slow_pin,
   input  logic       run_en,
   input  logic       gate_en,
   input  logic       ext_sel,
   input  logic [1:0] mode,
   input  logic [1:0] tbase,
   input  logic       buz_en,
   input  logic       wr_en,
   input  logic [1:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic [1:0] rd_addr,
   output logic [7:0] rd_data,
   input  logic       irq_ack,
   output logic       ovf_flag,
   output logic       irq,
   output logic       buz_oe,
   output logic       buz_out
);
   import tmr_pkg::*;

   logic [2:0]        div_tick;
   logic              cnt_fall, gate_lvl, slow_rise;
   logic              tb_tick, src_tick, cnt_tick;
   logic [BYTE_W-1:0] cnt_lo, cnt_hi;
   logic              reload_ovf, buz_q;

   tmr_prescaler #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick(div_tick)
   );

   tmr_sync #(.STAGES(SYNC_STAGES), .EDGE(EDGE_FALL)) u_sync_cnt (
      .clk(clk), .rst_n(rst_n), .pin(cnt_pin), .q(cnt_fall)
   );
   tmr_sync #(.STAGES(SYNC_STAGES), .EDGE(EDGE_LEVEL)) u_sync_gate (
      .clk(clk), .rst_n(rst_n), .pin(gate_pin), .q(gate_lvl)
   );
   tmr_sync #(.STAGES(SYNC_STAGES), .EDGE(EDGE_RISE)) u_sync_slow (
      .clk(clk), .rst_n(rst_n), .pin(slow_pin), .q(slow_rise)
   );

   always_comb begin
      unique case (tbase)
         2'b00:   tb_tick = div_tick[0];
         2'b01:   tb_tick = div_tick[1];
         2'b10:   tb_tick = div_tick[2];
         default: tb_tick = slow_rise;
      endcase
   end

   assign src_tick = ext_sel ? cnt_fall : tb_tick;
   assign cnt_tick = src_tick && run_en && (!gate_en || gate_lvl);

   tmr_core #(.LOW13(LOW13)) u_core (
      .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .mode(mode),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .irq_ack(irq_ack), .lo_q(cnt_lo), .hi_q(cnt_hi),
      .flag_q(ovf_flag), .reload_ovf(reload_ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          buz_q <= 1'b0;
      else if (reload_ovf) buz_q <= ~buz_q;
   end

   always_comb begin
      unique case (rd_addr)
         ADDR_LO:   rd_data = cnt_lo;
         ADDR_HI:   rd_data = cnt_hi;
         ADDR_FLAG: rd_data = {7'd0, ovf_flag};
         default:   rd_data = '0;
      endcase
   end

   assign irq     = ovf_flag;
   assign buz_oe  = buz_en;
   assign buz_out = buz_en ? buz_q : 1'bz;
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       run_en,
   input logic [1:0] mode,
   input logic       wr_en,
   input logic [1:0] wr_addr,
   input logic [7:0] wr_data,
   input logic       ovf_flag,
   input logic [7:0] cnt_lo,
   input logic [7:0] cnt_hi,
   input logic       buz_q
);
   assert_flag_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd2) |=> (ovf_flag == $past(wr_data[0])));

   assert_hold_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !wr_en) |=> $stable({cnt_hi, cnt_lo}));

   assert_hi_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && !wr_en) |=> $stable(cnt_hi));

   assert_upper_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00 && !wr_en) |=> $stable(cnt_lo[7:5]));

   assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b11 && !wr_en) |=> $stable({cnt_hi, cnt_lo}));

   assert_buz_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(buz_q) |-> ($past(mode) == 2'b10));

   assert_flag_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> ($past(run_en) || $past(wr_en && wr_addr == 2'd2)));
endmodule

bind tmr_unit tmr_unit_chk u_chk (
   .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode(mode),
   .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .ovf_flag(ovf_flag), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .buz_q(buz_q)
);

// File: tb/tmr_unit_tb.sv
`timescale 1ns/1ps
module tmr_unit_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cnt_pin = 1'b0, gate_pin = 1'b0, slow_pin = 1'b0;
   logic       run_en = 1'b0, gate_en = 1'b0, ext_sel = 1'b1;
   logic [1:0] mode = 2'b01, tbase = 2'b00;
   logic       buz_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] rd_data;
   logic       irq_ack = 1'b0;
   logic       ovf_flag, irq, buz_oe, buz_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tmr_unit u_dut (
      .clk(clk), .rst_n(rst_n), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
      .slow_pin(slow_pin), .run_en(run_en), .gate_en(gate_en),
      .ext_sel(ext_sel), .mode(mode), .tbase(tbase), .buz_en(buz_en),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq_ack(irq_ack),
      .ovf_flag(ovf_flag), .irq(irq), .buz_oe(buz_oe), .buz_out(buz_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         cnt_pin = 1'b1; repeat (3) @(negedge clk);
         cnt_pin = 1'b0; repeat (3) @(negedge clk);
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic load(input logic [7:0] hi, input logic [7:0] lo);
      wr(2'd1, hi); wr(2'd0, lo); wr(2'd2, 8'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      logic [7:0] lo, hi, fl;
      int exp_buz;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd0, lo); chk("R1 lo", lo, 0);
      rd(2'd1, hi); chk("R1 hi", hi, 0);
      chk("R1 flag", ovf_flag, 0);
      chk("R1 irq", irq, 0);
      chk("R1 buz_oe", buz_oe, 0);

      // R2 byte access
      load(8'hA5, 8'h3C);
      rd(2'd0, lo); chk("R2 lo", lo, 8'h3C);
      rd(2'd1, hi); chk("R2 hi", hi, 8'hA5);
      wr(2'd2, 8'h01);
      rd(2'd2, fl); chk("R2 flag write 1", fl, 1);
      wr(2'd2, 8'h00);
      rd(2'd2, fl); chk("R2 flag write 0", fl, 0);

      run_en = 1'b1;
      // R7 steady pin gives no count
      mode = 2'b01; load(8'h00, 8'h10);
      repeat (20) @(negedge clk);
      rd(2'd0, lo); chk("R7 steady pin", lo, 8'h10);
      pulses(7);
      rd(2'd0, lo); chk("R7 seven falls", lo, 8'h17);

      // R3 13-bit sweep from 1FFCh with upper bits E0
      mode = 2'b00; load(8'hFF, 8'hFC);
      for (int k = 1; k <= 6; k++) begin
         int v;
         pulses(1);
         v = (13'h1FFC + k) % 8192;
         rd(2'd0, lo); chk("R3 lo", lo, 8'hE0 | (v & 31));
         rd(2'd1, hi); chk("R3 hi", hi, v >> 5);
         chk("R3 flag", ovf_flag, (k >= 4) ? 1 : 0);
      end
      load(8'h12, 8'h1F); pulses(1);
      rd(2'd1, hi); chk("R3 carry hi", hi, 8'h13);
      rd(2'd0, lo); chk("R3 carry lo", lo, 8'h00);

      // R4 16-bit wrap
      mode = 2'b01; load(8'hFF, 8'hFE);
      pulses(1);
      chk("R4 no flag at FFFF", ovf_flag, 0);
      pulses(1);
      rd(2'd0, lo); rd(2'd1, hi);
      chk("R4 wrap", {hi, lo}, 0);
      chk("R4 flag", ovf_flag, 1);

      // R9 sticky flag, ack, irq
      repeat (10) @(negedge clk);
      chk("R9 sticky", ovf_flag, 1);
      chk("R9 irq", irq, 1);
      @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
      chk("R9 ack clears", ovf_flag, 0);
      chk("R9 irq clears", irq, 0);

      // R5 / R10 reload sweep, reload FAh (6 states), buzzer driven
      mode = 2'b10; buz_en = 1'b1; load(8'hFA, 8'hFA);
      chk("R10 buz_oe on", buz_oe, 1);
      exp_buz = 0;
      for (int k = 1; k <= 13; k++) begin
         pulses(1);
         rd(2'd0, lo); chk("R5 lo", lo, 8'hFA + (k % 6));
         rd(2'd1, hi); chk("R5 hi kept", hi, 8'hFA);
         exp_buz = (k / 6) % 2;
         chk("R10 buz", buz_out, exp_buz);
      end
      chk("R5 flag", ovf_flag, 1);
      buz_en = 1'b0; #1;
      chk("R10 buz_oe off", buz_oe, 0);

      // R11 hold mode
      mode = 2'b11; load(8'h55, 8'h66);
      pulses(4);
      rd(2'd0, lo); rd(2'd1, hi);
      chk("R11 hold", {hi, lo}, 16'h5566);

      // R6 gating
      mode = 2'b01; load(8'h00, 8'h00);
      run_en = 1'b0; pulses(3);
      rd(2'd0, lo); chk("R6 run off", lo, 0);
      run_en = 1'b1; gate_en = 1'b1; gate_pin = 1'b0;
      repeat (4) @(negedge clk);
      pulses(3);
      rd(2'd0, lo); chk("R6 gate low", lo, 0);
      gate_pin = 1'b1; repeat (4) @(negedge clk);
      pulses(2);
      rd(2'd0, lo); chk("R6 gate high", lo, 2);
      gate_en = 1'b0; gate_pin = 1'b0;

      // R8 time base over a 4096-cycle window
      run_en = 1'b0; ext_sel = 1'b0;
      for (int t = 0; t < 3; t++) begin
         int d;
         d = (t == 0) ? 4 : (t == 1) ? 64 : 1024;
         tbase = 2'(t); load(8'h00, 8'h00);
         @(negedge clk); run_en = 1'b1;
         repeat (4096) @(negedge clk);
         run_en = 1'b0;
         repeat (2) @(negedge clk);
         rd(2'd0, lo); rd(2'd1, hi);
         chk("R8 divider", {hi, lo}, 4096 / d);
      end
      tbase = 2'b11; load(8'h00, 8'h00);
      run_en = 1'b1;
      for (int i = 0; i < 20; i++) begin
         slow_pin = 1'b1; repeat (5) @(negedge clk);
         slow_pin = 1'b0; repeat (5) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      run_en = 1'b0;
      rd(2'd0, lo); chk("R8 slow clock", lo, 20);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule